// File: doc/BRIEF.md
# Pipelined Incrementing Burst Manager with Early Error Abort

This block is a bus manager for a single-layer AHB-Lite fabric. A client hands it one command: start address, beat count, transfer size, direction, and a seed for write data. The manager then runs an incrementing burst. The address phase of each beat overlaps the data phase of the beat before it, so a zero-wait subordinate completes one beat per clock. Write data for beat k is produced internally as seed + k. Read data is delivered on a one-cycle strobe for every beat that completes without error.

The manager watches the response signals during each data phase. When a subordinate begins an ERROR response, it does so in two cycles, and the first of those cycles has HREADY low. On that first cycle the manager pulls HTRANS back to IDLE in the same cycle. This withdraws the next beat, which was already on the bus. The errored beat is committed only on the cycle where HREADY is high. The withdrawn beat and every later beat are dropped and never retried.

When the burst ends, the manager raises a one-cycle done pulse. With it come an error flag, the number of beats that finished with an OKAY response and, after an error, the address of the beat that failed.

Top module: `ahb_burst_mgr`

## Requirements
- R1: While reset is asserted and after it is released, HTRANS is IDLE (2'b00), cmd_ready is high and done is low.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both high. In the next cycle the first address phase appears with HTRANS NONSEQ (2'b10) and HBURST INCR (3'b001). cmd_ready stays low while any address or data phase of the burst is outstanding.
- R3: Every beat after the first uses HTRANS SEQ (2'b11). HADDR advances by 2^HSIZE bytes per beat. A cmd_size larger than the bus width allows is reduced to the bus width. Beat k+1's address phase is driven while beat k is in its data phase, so with a zero-wait subordinate a burst of N beats raises done N+2 cycles after the accepting edge.
- R4: While HREADY is low and no error is being signalled, HADDR, HWRITE, HSIZE and HTRANS keep their values.
- R5: During the data phase of write beat k (counting from 0), HWDATA equals cmd_seed + k.
- R6: rd_valid is high for exactly one cycle after each read beat that completes with HREADY high and HRESP OKAY (0), and rd_data then holds that beat's HRDATA. rd_valid is never raised for an errored beat.
- R7: In any cycle where HRESP is ERROR (1) and HREADY is low during a data phase, HTRANS is IDLE in that same cycle.
- R8: After an ERROR response, no further address phase is issued, and HTRANS stays IDLE until a new command is accepted.
- R9: The cycle after the edge where HRESP is ERROR and HREADY is high, done pulses for one cycle. In that cycle done_err is 1, fault_addr holds the errored beat's address, and beats_ok holds the count of beats that completed OKAY.
- R10: The cycle after the final beat completes OKAY, done pulses with done_err 0 and beats_ok equal to cmd_len + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Manager idle and able to take a command |
| cmd_addr | input | AW | Byte address of the first beat |
| cmd_len | input | LEN_W | Beat count minus one |
| cmd_size | input | 3 | log2 of bytes per beat |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_seed | input | DW | Write data of beat 0; beat k carries seed + k |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type |
| hwrite | output | 1 | Transfer direction |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type, always incrementing |
| hwdata | output | DW | Write data |
| hready | input | 1 | Bus ready |
| hresp | input | 1 | Response, 1 = ERROR |
| hrdata | input | DW | Read data |
| rd_valid | output | 1 | Read beat delivered |
| rd_data | output | DW | Delivered read data |
| done | output | 1 | One-cycle end-of-burst pulse |
| done_err | output | 1 | Burst ended on an ERROR |
| fault_addr | output | AW | Address of the errored beat |
| beats_ok | output | LEN_W+1 | Beats that completed OKAY |

## Verification
The hardest case to produce is the warning cycle with the next beat already on the bus. HTRANS has to drop in that very cycle, and the drop must not be confused with a wait state. The bench subordinate answers any address at or above a fixed boundary with a two-cycle ERROR. It can also insert one wait state before each good beat. Bursts are started just below that boundary, so the failing beat falls on the first, a middle, or the last beat, under several transfer sizes and with and without wait states. A monitor samples every cycle. It checks that HTRANS is IDLE during each warning and that no address phase is accepted after the error. It also checks that the done pulse follows the completing error cycle by exactly one clock.

// File: rtl/ahb_bmgr_pkg.sv
`timescale 1ns/1ps
package ahb_bmgr_pkg;

   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } htrans_e;

   localparam logic [2:0] HBURST_INCR = 3'b001;
   localparam logic       RESP_OKAY   = 1'b0;
   localparam logic       RESP_ERROR  = 1'b1;

endpackage

// File: rtl/ahb_bmgr_phase_ctl.sv
`timescale 1ns/1ps
module ahb_bmgr_phase_ctl
   import ahb_bmgr_pkg::*;
(
   input  logic       a_valid,
   input  logic       a_first,
   input  logic       d_valid,
   input  logic       hready,
   input  logic       hresp,
   output logic [1:0] htrans,
   output logic       kill_addr,
   output logic       idle
);

   logic    warn_cyc;
   logic    commit_err;
   htrans_e tr;

   // first ERROR cycle: response present, transfer not yet complete
   assign warn_cyc   = d_valid && (hresp == RESP_ERROR) && !hready;
   assign commit_err = d_valid && (hresp == RESP_ERROR) && hready;
   assign kill_addr  = warn_cyc || commit_err;
   assign idle       = !a_valid && !d_valid;

   always_comb begin
      if (!a_valid || warn_cyc) begin
         tr = TR_IDLE;
      end else if (a_first) begin
         tr = TR_NONSEQ;
      end else begin
         tr = TR_SEQ;
      end
   end

   assign htrans = tr;

endmodule

// File: rtl/ahb_bmgr_addr_stage.sv
`timescale 1ns/1ps
module ahb_bmgr_addr_stage #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    cmd_addr,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic [2:0]       cmd_size,
   input  logic             cmd_write,
   input  logic [DW-1:0]    cmd_seed,
   input  logic             adv,
   input  logic             kill,
   output logic             a_valid,
   output logic             a_first,
   output logic [AW-1:0]    a_addr,
   output logic [LEN_W-1:0] a_idx,
   output logic [LEN_W-1:0] c_len,
   output logic [2:0]       c_size,
   output logic             c_write,
   output logic [DW-1:0]    c_seed
);

   localparam int MAX_SIZE = $clog2(DW / 8);
   localparam logic [LEN_W-1:0] IDX_ONE = LEN_W'(1);

   logic [2:0]    size_eff;
   logic [AW-1:0] step;

   generate
      if (MAX_SIZE >= 7) begin : g_noclamp
         assign size_eff = cmd_size;
      end else begin : g_clamp
         assign size_eff = (cmd_size > 3'(MAX_SIZE)) ? 3'(MAX_SIZE) : cmd_size;
      end
   endgenerate

   assign step = AW'(1) << c_size;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_valid <= 1'b0;
         a_first <= 1'b0;
         a_addr  <= '0;
         a_idx   <= '0;
         c_len   <= '0;
         c_size  <= '0;
         c_write <= 1'b0;
         c_seed  <= '0;
      end else if (load) begin
         a_valid <= 1'b1;
         a_first <= 1'b1;
         a_addr  <= cmd_addr;
         a_idx   <= '0;
         c_len   <= cmd_len;
         c_size  <= size_eff;
         c_write <= cmd_write;
         c_seed  <= cmd_seed;
      end else if (kill) begin
         // pending beat withdrawn, burst abandoned
         a_valid <= 1'b0;
      end else if (adv && a_valid) begin
         if (a_idx == c_len) begin
            a_valid <= 1'b0;
         end else begin
            a_addr  <= a_addr + step;
            a_idx   <= a_idx + IDX_ONE;
            a_first <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ahb_bmgr_data_stage.sv
`timescale 1ns/1ps
module ahb_bmgr_data_stage
   import ahb_bmgr_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   input  logic             hresp,
   input  logic             a_valid,
   input  logic [AW-1:0]    a_addr,
   input  logic [LEN_W-1:0] a_idx,
   input  logic [LEN_W-1:0] c_len,
   input  logic             c_write,
   input  logic [DW-1:0]    c_seed,
   input  logic [DW-1:0]    hrdata,
   output logic             d_valid,
   output logic [DW-1:0]    hwdata,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data,
   output logic             done,
   output logic             done_err,
   output logic [AW-1:0]    fault_addr,
   output logic [LEN_W:0]   beats_ok
);

   localparam int CNT_W = LEN_W + 1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [AW-1:0]    d_addr;
   logic [LEN_W-1:0] d_idx;
   logic [CNT_W-1:0] ok_cnt;
   logic             d_err;

   assign d_err  = d_valid && (hresp == RESP_ERROR);
   assign hwdata = (d_valid && c_write) ? (c_seed + DW'(d_idx)) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_valid    <= 1'b0;
         d_addr     <= '0;
         d_idx      <= '0;
         ok_cnt     <= '0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         done       <= 1'b0;
         done_err   <= 1'b0;
         fault_addr <= '0;
         beats_ok   <= '0;
      end else begin
         done     <= 1'b0;
         rd_valid <= 1'b0;
         if (load) begin
            ok_cnt <= '0;
         end
         if (adv) begin
            if (d_err) begin
               // completing ERROR cycle: commit, data invalid
               done       <= 1'b1;
               done_err   <= 1'b1;
               fault_addr <= d_addr;
               beats_ok   <= ok_cnt;
            end else if (d_valid) begin
               ok_cnt <= ok_cnt + CNT_ONE;
               if (!c_write) begin
                  rd_valid <= 1'b1;
                  rd_data  <= hrdata;
               end
               if (d_idx == c_len) begin
                  done     <= 1'b1;
                  done_err <= 1'b0;
                  beats_ok <= ok_cnt + CNT_ONE;
               end
            end
            d_valid <= a_valid && !d_err;
            d_addr  <= a_addr;
            d_idx   <= a_idx;
         end
      end
   end

endmodule

// File: rtl/ahb_burst_mgr.sv
`timescale 1ns/1ps
module ahb_burst_mgr
   import ahb_bmgr_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [AW-1:0]    cmd_addr,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic [2:0]       cmd_size,
   input  logic             cmd_write,
   input  logic [DW-1:0]    cmd_seed,
   output logic [AW-1:0]    haddr,
   output logic [1:0]       htrans,
   output logic             hwrite,
   output logic [2:0]       hsize,
   output logic [2:0]       hburst,
   output logic [DW-1:0]    hwdata,
   input  logic             hready,
   input  logic             hresp,
   input  logic [DW-1:0]    hrdata,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data,
   output logic             done,
   output logic             done_err,
   output logic [AW-1:0]    fault_addr,
   output logic [LEN_W:0]   beats_ok
);

   generate
      if (DW < 8 || DW > 1024 || (DW & (DW - 1)) != 0) begin : g_bad_dw
         $error("ahb_burst_mgr: DW must be a power of two from 8 to 1024");
      end
      if (AW < 8 || AW > 64) begin : g_bad_aw
         $error("ahb_burst_mgr: AW must lie in 8..64");
      end
      if (LEN_W < 1 || LEN_W >= DW) begin : g_bad_len
         $error("ahb_burst_mgr: LEN_W must be at least 1 and below DW");
      end
   endgenerate

   logic             a_valid;
   logic             a_first;
   logic [AW-1:0]    a_addr;
   logic [LEN_W-1:0] a_idx;
   logic [LEN_W-1:0] c_len;
   logic [2:0]       c_size;
   logic             c_write;
   logic [DW-1:0]    c_seed;
   logic             d_valid;
   logic             kill_addr;
   logic             idle;
   logic             load;

   assign cmd_ready = idle;
   assign load      = cmd_valid && idle;
   assign haddr     = a_addr;
   assign hwrite    = c_write;
   assign hsize     = c_size;
   assign hburst    = HBURST_INCR;

   ahb_bmgr_phase_ctl u_ctl (
      .a_valid   (a_valid),
      .a_first   (a_first),
      .d_valid   (d_valid),
      .hready    (hready),
      .hresp     (hresp),
      .htrans    (htrans),
      .kill_addr (kill_addr),
      .idle      (idle)
   );

   ahb_bmgr_addr_stage #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .cmd_addr  (cmd_addr),
      .cmd_len   (cmd_len),
      .cmd_size  (cmd_size),
      .cmd_write (cmd_write),
      .cmd_seed  (cmd_seed),
      .adv       (hready),
      .kill      (kill_addr),
      .a_valid   (a_valid),
      .a_first   (a_first),
      .a_addr    (a_addr),
      .a_idx     (a_idx),
      .c_len     (c_len),
      .c_size    (c_size),
      .c_write   (c_write),
      .c_seed    (c_seed)
   );

   ahb_bmgr_data_stage #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .adv        (hready),
      .hresp      (hresp),
      .a_valid    (a_valid),
      .a_addr     (a_addr),
      .a_idx      (a_idx),
      .c_len      (c_len),
      .c_write    (c_write),
      .c_seed     (c_seed),
      .hrdata     (hrdata),
      .d_valid    (d_valid),
      .hwdata     (hwdata),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .done       (done),
      .done_err   (done_err),
      .fault_addr (fault_addr),
      .beats_ok   (beats_ok)
   );

endmodule

// File: rtl/ahb_burst_mgr_chk.sv
`timescale 1ns/1ps
module ahb_burst_mgr_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic [AW-1:0] haddr,
   input logic [1:0]    htrans,
   input logic          hwrite,
   input logic [2:0]    hsize,
   input logic [2:0]    hburst,
   input logic          hready,
   input logic          hresp,
   input logic          done,
   input logic          done_err,
   input logic          rd_valid
);

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (htrans == 2'b00 && !done));

   p_start_nonseq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> (htrans == 2'b10 && hburst == 3'b001));

   p_busy_no_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans != 2'b00) |-> !cmd_ready);

   p_hold_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans != 2'b00 && !hready) |=>
         (haddr == $past(haddr) && hwrite == $past(hwrite) && hsize == $past(hsize)));

   p_no_rd_on_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_err) |-> !rd_valid);

   p_warn_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp && !hready && !cmd_ready) |-> (htrans == 2'b00));

   p_idle_after_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_err) |-> (htrans == 2'b00));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_commit_on_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_err) |-> $past(hresp && hready));

endmodule

bind ahb_burst_mgr ahb_burst_mgr_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .haddr     (haddr),
   .htrans    (htrans),
   .hwrite    (hwrite),
   .hsize     (hsize),
   .hburst    (hburst),
   .hready    (hready),
   .hresp     (hresp),
   .done      (done),
   .done_err  (done_err),
   .rd_valid  (rd_valid)
);

// File: tb/ahb_burst_mgr_tb.sv
`timescale 1ns/1ps
module ahb_burst_mgr_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LEN_W = 4;
   localparam logic [31:0] BAD_BASE = 32'h0000_1000;
   localparam logic [31:0] RD_PAT   = 32'h5A00_0000;

   typedef struct packed {
      logic [31:0] addr;
      logic [3:0]  len;
      logic        wr;
      logic [2:0]  size;
      logic        ws;
      logic [4:0]  ok;
      logic        err;
      logic [31:0] fault;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0100, 4'd3,  1'b0, 3'd2, 1'b0, 5'd4,  1'b0, 32'h0},
      '{32'h0000_0200, 4'd7,  1'b1, 3'd2, 1'b1, 5'd8,  1'b0, 32'h0},
      '{32'h0000_0FF8, 4'd5,  1'b1, 3'd2, 1'b0, 5'd2,  1'b1, 32'h1000},
      '{32'h0000_1000, 4'd3,  1'b0, 3'd2, 1'b1, 5'd0,  1'b1, 32'h1000},
      '{32'h0000_0FFE, 4'd3,  1'b0, 3'd1, 1'b0, 5'd1,  1'b1, 32'h1000},
      '{32'h0000_0FFC, 4'd0,  1'b1, 3'd2, 1'b0, 5'd1,  1'b0, 32'h0},
      '{32'h0000_0FF0, 4'd3,  1'b0, 3'd2, 1'b1, 5'd4,  1'b0, 32'h0},
      '{32'h0000_0FFC, 4'd1,  1'b1, 3'd2, 1'b0, 5'd1,  1'b1, 32'h1000},
      '{32'h0000_0FFF, 4'd2,  1'b0, 3'd0, 1'b1, 5'd1,  1'b1, 32'h1000},
      '{32'h0000_0300, 4'd1,  1'b0, 3'd3, 1'b0, 5'd2,  1'b0, 32'h0},
      '{32'h0000_0400, 4'd15, 1'b1, 3'd2, 1'b0, 5'd16, 1'b0, 32'h0}
   };

   logic             clk;
   logic             rst_n;
   logic             cmd_valid;
   logic             cmd_ready;
   logic [AW-1:0]    cmd_addr;
   logic [LEN_W-1:0] cmd_len;
   logic [2:0]       cmd_size;
   logic             cmd_write;
   logic [DW-1:0]    cmd_seed;
   logic [AW-1:0]    haddr;
   logic [1:0]       htrans;
   logic             hwrite;
   logic [2:0]       hsize;
   logic [2:0]       hburst;
   logic [DW-1:0]    hwdata;
   logic             hready;
   logic             hresp;
   logic [DW-1:0]    hrdata;
   logic             rd_valid;
   logic [DW-1:0]    rd_data;
   logic             done;
   logic             done_err;
   logic [AW-1:0]    fault_addr;
   logic [LEN_W:0]   beats_ok;

   ahb_burst_mgr #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size),
      .cmd_write(cmd_write), .cmd_seed(cmd_seed), .haddr(haddr),
      .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
      .hwdata(hwdata), .hready(hready), .hresp(hresp), .hrdata(hrdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .done_err(done_err),
      .fault_addr(fault_addr), .beats_ok(beats_ok)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // ---------------- subordinate model ----------------
   // phase: 0 okay/idle, 1 error warning, 2 error completion, 3 wait state
   logic [1:0]  s_ph;
   logic        s_dv;
   logic        s_dw;
   logic [31:0] s_daddr;
   logic        ws_en;

   assign hready = (s_ph == 2'd0) || (s_ph == 2'd2);
   assign hresp  = (s_ph == 2'd1) || (s_ph == 2'd2);
   assign hrdata = s_daddr ^ RD_PAT;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_ph <= 2'd0; s_dv <= 1'b0; s_dw <= 1'b0; s_daddr <= '0;
      end else if (hready) begin
         if (htrans[1]) begin
            s_dv <= 1'b1; s_daddr <= haddr; s_dw <= hwrite;
            if (haddr >= BAD_BASE) s_ph <= 2'd1;
            else if (ws_en)        s_ph <= 2'd3;
            else                   s_ph <= 2'd0;
         end else begin
            s_dv <= 1'b0; s_ph <= 2'd0;
         end
      end else if (s_ph == 2'd1) begin
         s_ph <= 2'd2;
      end else begin
         s_ph <= 2'd0;
      end
   end

   // ---------------- bus monitor (own counters) ----------------
   int          m_run, m_fail;
   int          mk;
   logic        m_err_seen;
   logic [31:0] m_start, m_seed;
   logic [2:0]  m_size;
   logic        p_rd, p_cmt, p_wait;
   logic [31:0] p_rd_exp, w_addr;
   logic [1:0]  w_tr;

   task automatic mchk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      m_run++;
      if (!ok) begin
         m_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   initial begin
      m_run = 0; m_fail = 0;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         mk = 0; m_err_seen = 1'b0; p_rd = 1'b0; p_cmt = 1'b0; p_wait = 1'b0;
         m_start = '0; m_seed = '0; m_size = '0; p_rd_exp = '0; w_addr = '0; w_tr = '0;
      end else begin
         if (p_rd) mchk(rd_valid && rd_data == p_rd_exp, "R6 read data", rd_data, p_rd_exp);
         else if (rd_valid) mchk(1'b0, "R6 unexpected rd_valid", 32'(rd_valid), 32'h0);
         if (p_cmt) mchk(done && done_err, "R9 done one cycle after commit", {30'h0, done, done_err}, 32'h3);
         if (p_wait) mchk(haddr == w_addr && htrans == w_tr, "R4 hold in wait", haddr, w_addr);
         p_rd = 1'b0; p_cmt = 1'b0; p_wait = 1'b0;

         if (cmd_valid && cmd_ready) begin
            mk = 0; m_err_seen = 1'b0;
            m_start = cmd_addr; m_seed = cmd_seed;
            m_size = (cmd_size > 3'd2) ? 3'd2 : cmd_size;
         end
         if (htrans[1] && hready) begin
            mchk(!m_err_seen, "R8 address issued after error", haddr, 32'h0);
            mchk(haddr == m_start + (32'(mk) << m_size), "R3 beat address", haddr,
                 m_start + (32'(mk) << m_size));
            mchk(htrans == ((mk == 0) ? 2'b10 : 2'b11), "R2/R3 htrans type", 32'(htrans),
                 (mk == 0) ? 32'h2 : 32'h3);
            mk++;
         end
         if (hresp && !hready) begin
            mchk(htrans == 2'b00, "R7 cancel in warning cycle", 32'(htrans), 32'h0);
            m_err_seen = 1'b1;
         end
         if (hresp && hready) p_cmt = 1'b1;
         if (!hready && !hresp && htrans[1]) begin
            p_wait = 1'b1; w_addr = haddr; w_tr = htrans;
         end
         if (s_dv && hready && !hresp) begin
            if (s_dw) begin
               mchk(hwdata == m_seed + ((s_daddr - m_start) >> m_size), "R5 write data",
                    hwdata, m_seed + ((s_daddr - m_start) >> m_size));
            end else begin
               p_rd = 1'b1; p_rd_exp = s_daddr ^ RD_PAT;
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   int n_run, n_fail;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic run_vec(input vec_t v);
      int cyc;
      @(negedge clk);
      chk(cmd_ready, "R2 ready when idle", 32'(cmd_ready), 32'h1);
      ws_en     = v.ws;
      cmd_addr  = v.addr;
      cmd_len   = v.len;
      cmd_size  = v.size;
      cmd_write = v.wr;
      cmd_seed  = 32'h1000_0000 + v.addr;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(!cmd_ready, "R2 ready low while busy", 32'(cmd_ready), 32'h0);
      cyc = 1;
      while (!done && cyc < 400) begin
         @(negedge clk);
         cyc++;
      end
      chk(cyc < 400, "R10 burst finished", cyc, 32'd400);
      chk(done_err == v.err, v.err ? "R9 error flag" : "R10 error flag", 32'(done_err), 32'(v.err));
      chk(beats_ok == v.ok, v.err ? "R9 beats ok" : "R10 beats ok", 32'(beats_ok), 32'(v.ok));
      if (v.err) chk(fault_addr == v.fault, "R9 fault address", fault_addr, v.fault);
      if (!v.ws && !v.err) chk(cyc == int'(v.len) + 3, "R3 pipelined beat rate", cyc, int'(v.len) + 3);
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         chk(htrans == 2'b00, "R8 idle after burst", 32'(htrans), 32'h0);
      end
   endtask

   initial begin
      n_run = 0; n_fail = 0;
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0;
      cmd_size = '0; cmd_write = 1'b0; cmd_seed = '0; ws_en = 1'b0;
      repeat (3) @(negedge clk);
      chk(htrans == 2'b00 && cmd_ready && !done, "R1 reset state",
          {29'h0, htrans, cmd_ready}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(htrans == 2'b00 && cmd_ready && !done, "R1 after release",
          {29'h0, htrans, cmd_ready}, 32'h1);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // reset in the middle of a burst
      @(negedge clk);
      ws_en = 1'b1; cmd_addr = 32'h500; cmd_len = 4'd15; cmd_size = 3'd2;
      cmd_write = 1'b0; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(htrans == 2'b00 && !done && cmd_ready, "R1 reset mid burst",
          {29'h0, htrans, cmd_ready}, 32'h1);
      rst_n = 1'b1;
      run_vec(VECS[0]);
      run_vec(VECS[7]);

      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run + m_run, n_fail + m_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run + m_run + 1, n_fail + m_fail + 1);
      $finish;
   end

endmodule